// File: doc/BRIEF.md
# Single-Channel Idle-Mode DMA Engine

This block is one DMA channel that moves a single byte or a single 16-bit word each time a selected request line fires. Software programs a fixed memory address, a fixed I/O address, a 16-bit transfer count and a control word. It then enables the channel. From then on, every activation on the chosen request line causes one bus read from the source address and one bus write to the destination address. Neither address moves between transfers. The direction of each move is not programmed. It follows from which request line was selected: receive-type sources move data from I/O to memory, and every other source moves data from memory to I/O.

Each completed transfer lowers the count by one. When the count arrives at zero, the channel disables itself and raises an interrupt to the CPU. A count loaded as zero runs the full 65,536 transfers. The interrupt is level-type and holds until software writes the control register again.

Top module: `dma_idle_chan`

## Requirements
- R1: After reset, every register (memory address, I/O address, count, control) reads 0, `irq` is 0 and `bus_req` is 0.
- R2: `reg_sel` chooses the register for a write or a combinational read: 0 is the memory address, 1 is the I/O address, 2 is the 16-bit count, 3 is control. Control bit fields: bit 0 enable, bit 1 word size (1 = 16-bit), bit 2 interrupt enable, bit 3 repeat enable, bits 6:4 source select, bit 7 a read-only done flag equal to `irq`.
- R3: An activation is accepted only while enable, interrupt enable and repeat enable are all 1. Otherwise it has no effect on the bus, the count or `irq`.
- R4: The source select picks one bit of `req_in`, and the other lines are ignored. Sources 5 and 7 move data from the I/O address to the memory address. Sources 0 to 4 and 6 move data from the memory address to the I/O address.
- R5: A transfer is one read of the source followed by one write to the destination. A word transfer forces address bit 0 to 0 and moves all 16 bits. A byte transfer writes the low 8 bits that were read, with the upper 8 bits at zero.
- R6: Both programmed addresses keep their values across transfers.
- R7: Each completed transfer decrements the count by 1. A count of 0 wraps to 0xFFFF after the first transfer, which gives 65,536 transfers in total.
- R8: The transfer that brings the count to 0 clears the enable bit and sets `irq`. Further activations are then ignored.
- R9: `irq` stays at 1 until any write to the control register, and that write clears it.
- R10: An activation is the rising edge of the selected line. An activation that arrives during a transfer is held and is served after that transfer finishes. At most one activation is held, so further edges during the same transfer merge into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data (combinational) |
| req_in | input | NREQ | Activation request lines |
| bus_req | output | 1 | Bus cycle request, held until acknowledged |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_word | output | 1 | 1 = 16-bit cycle, 0 = byte cycle |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid with `bus_ack` |
| bus_ack | input | 1 | Bus cycle completion |
| irq | output | 1 | Transfer-end interrupt |

## Verification
A wrong count register is visible at the ports in two ways. The count read back after each transfer is off by one. The `irq` edge also lands one transfer early or late, and this shows within one transfer time after the final activation. A wrong latched direction or size shows as data at the wrong address, or with wrong upper bits, when the bench memory is inspected after the same transfer. A lost or duplicated held activation changes the count read back within a couple of transfer times. Gating faults show up when a request on an unselected or disabled channel moves the count or touches the bus memory.

// File: rtl/dma_idle_pkg.sv
// Package: shared state encoding and control-field positions for the
// idle-mode DMA channel. Assumes an 8-bit control field as in R2.
package dma_idle_pkg;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_READ  = 2'd1,
        XS_WRITE = 2'd2
    } xfer_state_e;

    localparam int CTL_EN   = 0;
    localparam int CTL_WORD = 1;
    localparam int CTL_IE   = 2;
    localparam int CTL_RE   = 3;
    localparam int CTL_SRC  = 4;
    localparam int CTL_DONE = 7;
    localparam int CTL_W    = 8;

    localparam int CNT_W    = 16;
    localparam int DATA_W   = 16;

endpackage

// File: rtl/dma_regs.sv
// Register file of the channel: memory address, I/O address, count and
// control. Applies the count decrement and end-of-count handling on each
// completed transfer. Assumes software writes take priority over the
// decrement when both land in the same cycle.
module dma_regs
    import dma_idle_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SRC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] io_addr,
    output logic [CNT_W-1:0]  count,
    output logic              en,
    output logic              word,
    output logic              ie,
    output logic              re,
    output logic [SRC_W-1:0]  src,
    output logic              irq
);

    localparam logic [1:0] SEL_MEM = 2'd0;
    localparam logic [1:0] SEL_IO  = 2'd1;
    localparam logic [1:0] SEL_CNT = 2'd2;
    localparam logic [1:0] SEL_CTL = 2'd3;

    logic wr_mem, wr_io, wr_cnt, wr_ctl;
    logic last_xfer;

    // Decode write strobes and detect the transfer that exhausts the count.
    always_comb begin
        wr_mem    = reg_we && (reg_sel == SEL_MEM);
        wr_io     = reg_we && (reg_sel == SEL_IO);
        wr_cnt    = reg_we && (reg_sel == SEL_CNT);
        wr_ctl    = reg_we && (reg_sel == SEL_CTL);
        last_xfer = xfer_done && (count == CNT_W'(1));
    end

    // Address registers: change only on a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            io_addr  <= '0;
        end else begin
            if (wr_mem) mem_addr <= reg_wdata;
            if (wr_io)  io_addr  <= reg_wdata;
        end
    end

    // Count register: software load, else decrement per completed transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_cnt) begin
            count <= reg_wdata[CNT_W-1:0];
        end else if (xfer_done) begin
            count <= count - CNT_W'(1);
        end
    end

    // Control fields: software write, else auto-clear enable at end of count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            word <= 1'b0;
            ie   <= 1'b0;
            re   <= 1'b0;
            src  <= '0;
        end else if (wr_ctl) begin
            en   <= reg_wdata[CTL_EN];
            word <= reg_wdata[CTL_WORD];
            ie   <= reg_wdata[CTL_IE];
            re   <= reg_wdata[CTL_RE];
            src  <= reg_wdata[CTL_SRC +: SRC_W];
        end else if (last_xfer) begin
            en   <= 1'b0;
        end
    end

    // Interrupt flag: set at end of count, cleared by any control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (wr_ctl) begin
            irq <= 1'b0;
        end else if (last_xfer && ie) begin
            irq <= 1'b1;
        end
    end

    // Combinational readback of the selected register.
    always_comb begin
        unique case (reg_sel)
            SEL_MEM: reg_rdata = mem_addr;
            SEL_IO:  reg_rdata = io_addr;
            SEL_CNT: reg_rdata = ADDR_W'(count);
            default: reg_rdata = ADDR_W'({irq, src, re, ie, word, en});
        endcase
    end

    AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !wr_cnt) |=> (count == $past(count) - CNT_W'(1))); // R7
    AST_ADDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !wr_mem && !wr_io) |=> ($stable(mem_addr) && $stable(io_addr))); // R6
    AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (!en && count == '0)); // R8
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_ctl) |=> irq); // R9

endmodule

// File: rtl/dma_req.sv
// Activation logic: picks the selected request line, detects its rising
// edge, holds one activation while a transfer runs and reports the
// direction of the source. Assumes request lines are synchronous to clk.
module dma_req #(
    parameter int NREQ = 8,
    parameter int SRC_W = $clog2(NREQ),
    parameter logic [NREQ-1:0] TO_MEM_MASK = 8'b1010_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREQ-1:0]  req_in,
    input  logic [SRC_W-1:0] src,
    input  logic             active,
    input  logic             xfer_idle,
    output logic             start,
    output logic             to_mem
);

    logic [NREQ-1:0] req_q;
    logic [NREQ-1:0] edge_vec;
    logic            pend;
    logic            act;

    // Per-line rising-edge detect, one instance per request line.
    for (genvar i = 0; i < NREQ; i++) begin : g_edge
        always_ff @(posedge clk) begin
            if (!rst_n) req_q[i] <= 1'b0;
            else        req_q[i] <= req_in[i];
        end
        assign edge_vec[i] = req_in[i] & ~req_q[i];
    end

    // Select the activation edge and direction for the chosen source.
    always_comb begin
        act    = edge_vec[src];
        to_mem = TO_MEM_MASK[src];
        start  = pend && xfer_idle && active;
    end

    // One-deep pending activation; dropped whenever the channel is inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (!active) begin
            pend <= 1'b0;
        end else if (act) begin
            pend <= 1'b1;
        end else if (start) begin
            pend <= 1'b0;
        end
    end

    AST_OFF_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !pend); // R3
    AST_HELD_UNTIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !xfer_idle && active) |=> pend); // R10

endmodule

// File: rtl/dma_xfer.sv
// Transfer sequencer: for each start, one read of the source and one write
// of the destination on a request/acknowledge bus. Latches addresses,
// direction and size at start. Assumes bus_ack arrives only while bus_req
// is high.
module dma_xfer
    import dma_idle_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              to_mem,
    input  logic              word,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              done,
    output logic              idle
);

    xfer_state_e       state;
    logic              word_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] rd_pick, wr_pick;
    logic [ADDR_W-1:0] align_mask;

    // Choose source/destination by direction and align for word size.
    always_comb begin
        align_mask = word ? ~ADDR_W'(1) : '1;
        rd_pick    = (to_mem ? io_addr  : mem_addr) & align_mask;
        wr_pick    = (to_mem ? mem_addr : io_addr)  & align_mask;
    end

    // Phase sequencer: idle -> read -> write -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= XS_IDLE;
        end else begin
            unique case (state)
                XS_IDLE:  if (start)   state <= XS_READ;
                XS_READ:  if (bus_ack) state <= XS_WRITE;
                XS_WRITE: if (bus_ack) state <= XS_IDLE;
                default:               state <= XS_IDLE;
            endcase
        end
    end

    // Latch transfer parameters at start so they hold for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= 1'b0;
            rd_addr_q <= '0;
            wr_addr_q <= '0;
        end else if (state == XS_IDLE && start) begin
            word_q    <= word;
            rd_addr_q <= rd_pick;
            wr_addr_q <= wr_pick;
        end
    end

    // Capture read data, zero-extending byte transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (state == XS_READ && bus_ack) begin
            data_q <= word_q ? bus_rdata : {8'h00, bus_rdata[7:0]};
        end
    end

    // Drive the bus from the current phase.
    always_comb begin
        bus_req   = (state == XS_READ) || (state == XS_WRITE);
        bus_we    = (state == XS_WRITE);
        bus_word  = word_q;
        bus_addr  = (state == XS_WRITE) ? wr_addr_q : rd_addr_q;
        bus_wdata = data_q;
        done      = (state == XS_WRITE) && bus_ack;
        idle      = (state == XS_IDLE);
    end

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we))); // R5
    AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_word) |-> !bus_addr[0]); // R5
    AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ack) |=> (bus_req && bus_we)); // R5

endmodule

// File: rtl/dma_idle_chan.sv
// Top of the idle-mode DMA channel: register file, activation logic and
// transfer sequencer. Assumes a single bus master port with no arbitration
// and request lines synchronous to clk.
module dma_idle_chan
    import dma_idle_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int NREQ   = 8,
    parameter logic [NREQ-1:0] TO_MEM_MASK = 8'b1010_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic [NREQ-1:0]   req_in,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [15:0]       bus_wdata,
    input  logic [15:0]       bus_rdata,
    input  logic              bus_ack,
    output logic              irq
);

    localparam int SRC_W = $clog2(NREQ);

    logic [ADDR_W-1:0] mem_addr, io_addr;
    logic [CNT_W-1:0]  count;
    logic              en, word, ie, re;
    logic [SRC_W-1:0]  src;
    logic              active, start, to_mem, done, idle;

    // Channel is live only in idle mode with enable set.
    always_comb active = en && ie && re;

    dma_regs #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(done),
        .mem_addr(mem_addr), .io_addr(io_addr), .count(count),
        .en(en), .word(word), .ie(ie), .re(re), .src(src), .irq(irq)
    );

    dma_req #(.NREQ(NREQ), .SRC_W(SRC_W), .TO_MEM_MASK(TO_MEM_MASK)) req_i (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .src(src),
        .active(active), .xfer_idle(idle), .start(start), .to_mem(to_mem)
    );

    dma_xfer #(.ADDR_W(ADDR_W)) xfer_i (
        .clk(clk), .rst_n(rst_n), .start(start), .to_mem(to_mem),
        .word(word), .mem_addr(mem_addr), .io_addr(io_addr),
        .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .done(done), .idle(idle)
    );

    AST_NO_BUS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && idle) |=> !bus_req); // R3
    AST_START_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(active)); // R8

endmodule

// File: tb/dma_idle_chan_tb_top.sv
module dma_idle_chan_tb_top;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic [7:0]    req_in = 8'h00;
    logic          bus_req, bus_we, bus_word;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_wdata;
    logic [15:0]   bus_rdata = 16'h0;
    logic          bus_ack = 1'b0;
    logic          irq;

    int errors = 0;
    int checks = 0;
    int lat = 1;
    int lat_cnt = 1;
    logic [15:0] bmem [0:255];
    logic done_flag = 1'b0;

    always #4 clk = ~clk;

    dma_idle_chan dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_in(req_in),
        .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .irq(irq)
    );

    // Bus slave model with programmable latency.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                if (lat_cnt > lat) lat_cnt = lat;
                if (lat_cnt == 0) begin
                    bus_ack = 1'b1;
                    bus_rdata = bmem[bus_addr[7:0]];
                    if (bus_we) bmem[bus_addr[7:0]] = bus_wdata;
                    lat_cnt = lat;
                end else begin
                    lat_cnt = lat_cnt - 1;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [AW-1:0] ctl(input logic en, input logic wd,
                                          input logic ie, input logic re,
                                          input logic [2:0] s);
        return AW'({s, re, ie, wd, en});
    endfunction

    function automatic logic [15:0] exp_move(input logic [15:0] v, input logic wd);
        return wd ? v : {8'h00, v[7:0]};
    endfunction

    function automatic logic dir_to_mem(input logic [2:0] s);
        return (s == 3'd5) || (s == 3'd7);
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [AW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [AW-1:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        req_in[line] = 1'b1;
        @(negedge clk);
        req_in[line] = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [AW-1:0] r;
    logic [15:0]   v;

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) bmem[i] = 16'(i * 16'h0101);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int k = 0; k < 4; k++) begin
            rd(2'(k), r);
            check(r == '0, "R1 register reset", 32'(r), 0);
        end
        check(irq == 1'b0 && bus_req == 1'b0, "R1 irq/bus_req reset", {irq, bus_req}, 0);

        // R2: register readback and field positions
        wr(2'd0, 24'hABCDEF); rd(2'd0, r);
        check(r == 24'hABCDEF, "R2 mem addr readback", 32'(r), 32'hABCDEF);
        wr(2'd1, 24'h123456); rd(2'd1, r);
        check(r == 24'h123456, "R2 io addr readback", 32'(r), 32'h123456);
        wr(2'd3, ctl(1'b0, 1'b1, 1'b0, 1'b1, 3'd6)); rd(2'd3, r);
        check(r == 24'h6A, "R2 control fields", 32'(r), 32'h6A);

        // R3: disabled channel ignores activation
        lat = 1;
        wr(2'd0, 24'h10); wr(2'd1, 24'h90); wr(2'd2, 24'd3);
        bmem[8'h10] = 16'h1111; bmem[8'h90] = 16'h2222;
        wr(2'd3, ctl(1'b0, 1'b1, 1'b1, 1'b1, 3'd0));
        pulse(0); settle(20); rd(2'd2, r);
        check(r == 24'd3 && bmem[8'h90] == 16'h2222, "R3 disabled ignores", 32'(r), 3);
        // R3: repeat enable clear (not idle mode) ignores activation
        wr(2'd3, ctl(1'b1, 1'b1, 1'b1, 1'b0, 3'd0));
        pulse(0); settle(20); rd(2'd2, r);
        check(r == 24'd3 && bmem[8'h90] == 16'h2222, "R3 non-idle ignores", 32'(r), 3);

        // R4: unselected line ignored
        wr(2'd3, ctl(1'b1, 1'b1, 1'b1, 1'b1, 3'd0));
        pulse(3); settle(20); rd(2'd2, r);
        check(r == 24'd3, "R4 unselected line ignored", 32'(r), 3);
        // R4/R5: word memory to I/O on source 0
        pulse(0); settle(20);
        check(bmem[8'h90] == 16'h1111, "R4 mem->io word", 32'(bmem[8'h90]), 32'h1111);
        rd(2'd2, r);
        check(r == 24'd2, "R7 count decrement", 32'(r), 2);

        // R10: rising edge only, held while busy, extra edges merged
        lat = 3;
        @(negedge clk); req_in[0] = 1'b1; settle(30); req_in[0] = 1'b0; settle(2);
        rd(2'd2, r);
        check(r == 24'd1, "R10 level counts once", 32'(r), 1);
        wr(2'd2, 24'd5);
        pulse(0); settle(1); pulse(0); settle(1); pulse(0);
        settle(60); rd(2'd2, r);
        check(r == 24'd3, "R10 held and merged", 32'(r), 3);

        // R5: word forces even address; byte zero-extends
        lat = 0;
        wr(2'd0, 24'h21); wr(2'd1, 24'hA1); wr(2'd2, 24'd4);
        bmem[8'h20] = 16'hBEEF; bmem[8'hA0] = 16'h0; bmem[8'hA1] = 16'h0;
        wr(2'd3, ctl(1'b1, 1'b1, 1'b1, 1'b1, 3'd4));
        pulse(4); settle(15);
        check(bmem[8'hA0] == 16'hBEEF, "R5 word even address", 32'(bmem[8'hA0]), 32'hBEEF);
        bmem[8'h21] = 16'hC3A5;
        wr(2'd3, ctl(1'b1, 1'b0, 1'b1, 1'b1, 3'd4));
        pulse(4); settle(15);
        check(bmem[8'hA1] == 16'h00A5, "R5 byte zero-extend", 32'(bmem[8'hA1]), 32'hA5);

        // R7: zero count wraps to 0xFFFF and channel stays enabled
        wr(2'd2, 24'd0);
        wr(2'd3, ctl(1'b1, 1'b1, 1'b1, 1'b1, 3'd1));
        pulse(1); settle(15); rd(2'd2, r);
        check(r == 24'hFFFF, "R7 zero means 65536", 32'(r), 32'hFFFF);
        rd(2'd3, r);
        check(r[0] == 1'b1 && irq == 1'b0, "R7 still enabled after wrap", {r[0], irq}, 2);

        // Random: direction, size, count, latency; end-of-count behaviour
        for (int t = 0; t < 24; t++) begin
            logic [2:0] s;
            logic wd;
            int n;
            logic [7:0] ma, ia, sa, da;
            s  = 3'($urandom_range(0, 7));
            wd = 1'($urandom_range(0, 1));
            n  = $urandom_range(1, 4);
            lat = $urandom_range(0, 3);
            ma = 8'($urandom_range(8'h10, 8'h7F));
            ia = 8'($urandom_range(8'h80, 8'hFF));
            if (wd) begin ma[0] = 1'b0; ia[0] = 1'b0; end
            sa = dir_to_mem(s) ? ia : ma;
            da = dir_to_mem(s) ? ma : ia;
            wr(2'd0, AW'(ma)); wr(2'd1, AW'(ia)); wr(2'd2, AW'(n));
            wr(2'd3, ctl(1'b1, wd, 1'b1, 1'b1, s));
            for (int k = 0; k < n; k++) begin
                v = 16'($urandom());
                bmem[sa] = v;
                pulse(int'(s)); settle(20);
                check(bmem[da] == exp_move(v, wd), "R4 R5 random move data",
                      32'(bmem[da]), 32'(exp_move(v, wd)));
                if (k < n - 1)
                    check(irq == 1'b0, "R8 no early irq", 32'(irq), 0);
            end
            rd(2'd2, r);
            check(r == '0, "R7 count exhausted", 32'(r), 0);
            rd(2'd3, r);
            check(r[0] == 1'b0 && r[7] == 1'b1 && irq == 1'b1, "R8 enable cleared, irq set",
                  {r[7], r[0], irq}, 3'b101);
            rd(2'd0, r);
            check(r == AW'(ma), "R6 mem addr fixed", 32'(r), 32'(ma));
            rd(2'd1, r);
            check(r == AW'(ia), "R6 io addr fixed", 32'(r), 32'(ia));
            // R8: activation after end is ignored
            v = bmem[da];
            bmem[sa] = ~v;
            pulse(int'(s)); settle(20);
            check(bmem[da] == v, "R8 ignored after end", 32'(bmem[da]), 32'(v));
            check(irq == 1'b1, "R9 irq holds", 32'(irq), 1);
            wr(2'd3, ctl(1'b0, wd, 1'b1, 1'b1, s));
            settle(1);
            check(irq == 1'b0, "R9 control write clears irq", 32'(irq), 0);
        end

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule